// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the ordered word addresses for a transfer that moves a group of registers to or from memory in one operation. Software or a decoder presents a base address, a mask with one bit per register, an addressing mode, a load/store flag and a writeback request, then pulses `start`. The block counts the selected registers. It works out where the group begins in memory and streams one beat per selected register. Each beat carries the register number and the word address.

The beat stream is valid/ready. A beat is presented with `beat_valid` high and stays unchanged until `beat_ready` is sampled high at a rising edge. At most one beat moves per clock. When the last beat is taken, `done` pulses for one cycle. The updated base and a writeback enable appear alongside that pulse. A sequence that has started always runs to its end. While it runs, `start` has no effect.

The mode can be given directly as one of four basic orderings. It can also be given as a stack convention, which the block turns into a basic ordering that depends on whether the transfer loads or stores.

Top module: `blk_xfer_seq`

## Requirements
- R1: With basic modes encoded as 0 = increment-after, 1 = increment-before, 2 = decrement-after, 3 = decrement-before, and N registers selected, the first beat address is base, base+4, base-4N+4 and base-4N respectively.
- R2: Beats carry the selected register numbers in ascending order. Each beat's address is 4 more than the previous one, and there are exactly N beats.
- R3: When `wback` was set at start, `done` comes with `wb_en` high and `new_base` equal to base+4N for the increment modes or base-4N for the decrement modes. Without `wback`, `wb_en` stays low and `new_base` equals the base.
- R4: With `use_stack` high, `mode_code` selects 0 = full-descending, 1 = full-ascending, 2 = empty-descending, 3 = empty-ascending. For stores these become decrement-before, increment-before, decrement-after and increment-after. For loads they become increment-after, decrement-after, increment-before and decrement-before.
- R5: The two low bits of the base are treated as zero. Every beat address and every reported base is word aligned.
- R6: While `beat_ready` is low, a presented beat keeps `beat_valid` high and holds its register number and address.
- R7: `done` is high for exactly one cycle, in the cycle after the last beat is accepted. `busy` is high from the cycle after start until the end of that cycle, and is low afterwards.
- R8: A `start` pulse while `busy` is high is ignored. The running sequence keeps its beats, its count and its final base.
- R9: An all-zero mask produces no beats. It raises `done` together with `err` one cycle after start, with `wb_en` low and `new_base` equal to the base.
- R10: After reset, `busy`, `beat_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sequence (sampled when idle) |
| base_addr | input | ADDR_W | Base address |
| reg_mask | input | MASK_W | One bit per register to transfer |
| mode_code | input | 2 | Basic mode or stack convention code |
| use_stack | input | 1 | Interpret `mode_code` as a stack convention |
| is_load | input | 1 | 1 = load, 0 = store |
| wback | input | 1 | Request base writeback |
| busy | output | 1 | Sequence in progress |
| beat_valid | output | 1 | A beat is presented |
| beat_ready | input | 1 | Consumer accepts the presented beat |
| beat_reg | output | $clog2(MASK_W) | Register number of the beat |
| beat_addr | output | ADDR_W | Word address of the beat |
| beat_load | output | 1 | Direction of the beat (1 = load) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Empty mask, qualified by `done` |
| wb_en | output | 1 | Write `new_base` back, qualified by `done` |
| new_base | output | ADDR_W | Updated base value |

## Verification
The bench uses the default parameters: 32-bit addresses, a 16-entry mask and 4-byte words. With these values a full mask drives the population count to its top value of 16 and the picker to index 15. The span then covers 64 bytes, so the decrement modes reach the widest subtraction. The small mask widths seen in the three-register memory example sit next to these extremes. The same build also covers an unaligned base, a stalled consumer and a start pulse that arrives mid-sequence.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  typedef enum logic [1:0] {
    XM_INC_AFTER  = 2'd0,
    XM_INC_BEFORE = 2'd1,
    XM_DEC_AFTER  = 2'd2,
    XM_DEC_BEFORE = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    SK_FULL_DESC  = 2'd0,
    SK_FULL_ASC   = 2'd1,
    SK_EMPTY_DESC = 2'd2,
    SK_EMPTY_ASC  = 2'd3
  } stack_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bxs_mode_map.sv
module bxs_mode_map
  import bxs_pkg::*;
(
  input  logic [1:0]  mode_code,
  input  logic        use_stack,
  input  logic        is_load,
  output xfer_mode_e  mode_out
);
  always_comb begin
    if (!use_stack) begin
      mode_out = xfer_mode_e'(mode_code);
    end else begin
      unique case (stack_kind_e'(mode_code))
        SK_FULL_DESC:  mode_out = is_load ? XM_INC_AFTER  : XM_DEC_BEFORE;
        SK_FULL_ASC:   mode_out = is_load ? XM_DEC_AFTER  : XM_INC_BEFORE;
        SK_EMPTY_DESC: mode_out = is_load ? XM_INC_BEFORE : XM_DEC_AFTER;
        default:       mode_out = is_load ? XM_DEC_BEFORE : XM_INC_AFTER;
      endcase
    end
  end
endmodule

// File: rtl/bxs_span.sv
module bxs_span
  import bxs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 16,
  parameter int STEP_B = 4,
  localparam int CNT_W = $clog2(MASK_W + 1)
) (
  input  logic [ADDR_W-1:0] base_al,
  input  logic [MASK_W-1:0] mask,
  input  xfer_mode_e        mode,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] end_base
);
  localparam int AL_W = $clog2(STEP_B);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_B);

  logic [ADDR_W-1:0] span;

  always_comb begin
    count = '0;
    for (int i = 0; i < MASK_W; i++) begin
      count = count + CNT_W'(mask[i]);
    end
  end

  assign span = ADDR_W'(count) << AL_W;

  always_comb begin
    unique case (mode)
      XM_INC_AFTER: begin
        first_addr = base_al;
        end_base   = base_al + span;
      end
      XM_INC_BEFORE: begin
        first_addr = base_al + STEP;
        end_base   = base_al + span;
      end
      XM_DEC_AFTER: begin
        first_addr = base_al - span + STEP;
        end_base   = base_al - span;
      end
      default: begin
        first_addr = base_al - span;
        end_base   = base_al - span;
      end
    endcase
  end
endmodule

// File: rtl/bxs_picker.sv
module bxs_picker #(
  parameter int MASK_W = 16,
  localparam int IDX_W = $clog2(MASK_W)
) (
  input  logic [MASK_W-1:0] vec,
  output logic [IDX_W-1:0]  idx,
  output logic [MASK_W-1:0] onehot
);
  always_comb begin
    idx = '0;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    onehot = (vec == '0) ? '0 : (MASK_W'(1) << idx);
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import bxs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MASK_W = 16,
  parameter int STEP_B = 4,
  localparam int IDX_W = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [MASK_W-1:0] reg_mask,
  input  logic [1:0]        mode_code,
  input  logic              use_stack,
  input  logic              is_load,
  input  logic              wback,
  output logic              busy,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [IDX_W-1:0]  beat_reg,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_load,
  output logic              done,
  output logic              err,
  output logic              wb_en,
  output logic [ADDR_W-1:0] new_base
);
  localparam int AL_W  = $clog2(STEP_B);
  localparam int CNT_W = $clog2(MASK_W + 1);

  seq_state_e        st_q;
  xfer_mode_e        mode_sel;
  logic [ADDR_W-1:0] base_al;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] first_a, end_b;
  logic [MASK_W-1:0] rem_q, pick_oh, rem_next;
  logic [IDX_W-1:0]  pick_idx;
  logic [ADDR_W-1:0] addr_q, nb_q;
  logic              ld_q, wb_q, err_q;

  assign base_al = {base_addr[ADDR_W-1:AL_W], AL_W'(0)};

  bxs_mode_map u_map (
    .mode_code (mode_code),
    .use_stack (use_stack),
    .is_load   (is_load),
    .mode_out  (mode_sel)
  );

  bxs_span #(.ADDR_W(ADDR_W), .MASK_W(MASK_W), .STEP_B(STEP_B)) u_span (
    .base_al    (base_al),
    .mask       (reg_mask),
    .mode       (mode_sel),
    .count      (cnt),
    .first_addr (first_a),
    .end_base   (end_b)
  );

  bxs_picker #(.MASK_W(MASK_W)) u_pick (
    .vec    (rem_q),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  assign rem_next = rem_q & ~pick_oh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      addr_q <= '0;
      nb_q   <= '0;
      ld_q   <= 1'b0;
      wb_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            ld_q   <= is_load;
            err_q  <= (cnt == '0);
            wb_q   <= wback && (cnt != '0);
            nb_q   <= (wback && (cnt != '0)) ? end_b : base_al;
            rem_q  <= reg_mask;
            addr_q <= first_a;
            st_q   <= (cnt == '0) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (beat_ready) begin
            rem_q  <= rem_next;
            addr_q <= addr_q + ADDR_W'(STEP_B);
            if (rem_next == '0) st_q <= ST_FIN;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign beat_valid = (st_q == ST_RUN);
  assign beat_reg   = pick_idx;
  assign beat_addr  = addr_q;
  assign beat_load  = ld_q;
  assign done       = (st_q == ST_FIN);
  assign err        = done && err_q;
  assign wb_en      = done && wb_q;
  assign new_base   = nb_q;
endmodule

// File: rtl/bxs_checker.sv
module bxs_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [IDX_W-1:0]  beat_reg,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              done,
  input logic              err,
  input logic              wb_en
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_reg)));

  p_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_addr[1:0] == 2'b00));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready) |=> (!beat_valid || (beat_addr == $past(beat_addr) + ADDR_W'(4))));

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready) |=> (!beat_valid || (beat_reg > $past(beat_reg))));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !wb_en && !beat_valid));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!beat_valid && !done));

  p_wb_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);
endmodule

bind blk_xfer_seq bxs_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_reg   (beat_reg),
  .beat_addr  (beat_addr),
  .done       (done),
  .err        (err),
  .wb_en      (wb_en)
);

// File: tb/sim_blk_xfer_seq.sv
`timescale 1ns/1ps
module sim_blk_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] reg_mask = '0;
  logic [1:0]  mode_code = '0;
  logic        use_stack = 1'b0;
  logic        is_load = 1'b0;
  logic        wback = 1'b0;
  logic        rdy = 1'b1;
  logic        busy, beat_valid, beat_load, done, err, wb_en;
  logic [3:0]  beat_reg;
  logic [31:0] beat_addr, new_base;

  always #2.5 clk = ~clk;

  blk_xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .reg_mask(reg_mask), .mode_code(mode_code), .use_stack(use_stack),
    .is_load(is_load), .wback(wback), .busy(busy), .beat_valid(beat_valid),
    .beat_ready(rdy), .beat_reg(beat_reg), .beat_addr(beat_addr),
    .beat_load(beat_load), .done(done), .err(err), .wb_en(wb_en),
    .new_base(new_base)
  );

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] mem [256];
  logic [31:0] regs [16];

  int          got_n, got_lat;
  logic [31:0] got_first, got_nb;
  bit          got_wb, got_err, got_done, got_step_ok, got_order_ok, got_hold_ok, got_after;

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] mask;
    logic [1:0]  mc;
    logic        stk;
    logic        ld;
    logic        wb;
    logic [31:0] first;
    logic [4:0]  n;
    logic [31:0] nb;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h10,  16'h000E, 2'd0, 1'b0, 1'b1, 1'b1, 32'h10,  5'd3,  32'h1C},
    '{32'h10,  16'h000E, 2'd1, 1'b0, 1'b1, 1'b1, 32'h14,  5'd3,  32'h1C},
    '{32'h24,  16'h000E, 2'd2, 1'b0, 1'b1, 1'b1, 32'h1C,  5'd3,  32'h18},
    '{32'h24,  16'h000E, 2'd3, 1'b0, 1'b1, 1'b1, 32'h18,  5'd3,  32'h18},
    '{32'h100, 16'h8001, 2'd0, 1'b1, 1'b0, 1'b1, 32'hF8,  5'd2,  32'hF8},
    '{32'h100, 16'h8001, 2'd0, 1'b1, 1'b1, 1'b1, 32'h100, 5'd2,  32'h108},
    '{32'h40,  16'h00F0, 2'd1, 1'b1, 1'b0, 1'b1, 32'h44,  5'd4,  32'h50},
    '{32'h40,  16'h00F0, 2'd1, 1'b1, 1'b1, 1'b1, 32'h34,  5'd4,  32'h30},
    '{32'h80,  16'h0001, 2'd2, 1'b1, 1'b0, 1'b1, 32'h80,  5'd1,  32'h7C},
    '{32'h80,  16'h0001, 2'd2, 1'b1, 1'b1, 1'b1, 32'h84,  5'd1,  32'h84},
    '{32'h80,  16'hFFFF, 2'd3, 1'b1, 1'b0, 1'b1, 32'h80,  5'd16, 32'hC0},
    '{32'h80,  16'hFFFF, 2'd3, 1'b1, 1'b1, 1'b1, 32'h40,  5'd16, 32'h40},
    '{32'h200, 16'h0505, 2'd0, 1'b0, 1'b1, 1'b0, 32'h200, 5'd4,  32'h200},
    '{32'h13,  16'h0003, 2'd0, 1'b0, 1'b0, 1'b1, 32'h10,  5'd2,  32'h18},
    '{32'h27,  16'h0001, 2'd3, 1'b0, 1'b1, 1'b1, 32'h20,  5'd1,  32'h20}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int w = 0; w < 256; w++) mem[w] = (w >= 4) ? 32'((w - 3) * 10) : 32'd0;
    for (int r = 0; r < 16; r++) regs[r] = 32'hA0 + 32'(r);
  endtask

  task automatic run_seq(input logic [31:0] b, input logic [15:0] m, input logic [1:0] mc,
                         input logic sk, input logic ld, input logic wb,
                         input int stall, input bit poke);
    int cyc;
    int prev_r;
    logic [31:0] prev_a, hold_a;
    logic [3:0]  hold_r;
    got_n = 0; got_lat = 0; got_done = 0; got_step_ok = 1; got_order_ok = 1; got_hold_ok = 1;
    prev_r = -1; prev_a = '0; hold_a = '0; hold_r = '0;
    @(negedge clk);
    base_addr = b; reg_mask = m; mode_code = mc; use_stack = sk; is_load = ld; wback = wb;
    start = 1'b1; rdy = (stall == 0);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (cyc < 200) begin
      if (poke && cyc == 1) begin
        start = 1'b1; reg_mask = 16'hFFFF; base_addr = 32'h300; mode_code = 2'd3;
      end else start = 1'b0;
      if (done) begin
        got_lat = cyc; got_nb = new_base; got_wb = wb_en; got_err = err; got_done = 1;
        break;
      end
      if (cyc <= stall) begin
        if (!beat_valid) got_hold_ok = 0;
        else if (cyc == 1) begin hold_a = beat_addr; hold_r = beat_reg; end
        else if (beat_addr !== hold_a || beat_reg !== hold_r) got_hold_ok = 0;
        if (cyc == stall) rdy = 1'b1;
      end
      if (rdy && beat_valid) begin
        if (got_n == 0) got_first = beat_addr;
        else begin
          if (beat_addr !== prev_a + 32'd4) got_step_ok = 0;
          if (int'(beat_reg) <= prev_r) got_order_ok = 0;
        end
        if (!m[beat_reg]) got_order_ok = 0;
        prev_a = beat_addr; prev_r = int'(beat_reg);
        if (beat_load) regs[beat_reg] = mem[beat_addr[9:2]];
        else mem[beat_addr[9:2]] = regs[beat_reg];
        got_n++;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    rdy = 1'b1;
    @(negedge clk);
    got_after = done || busy;
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog expired act=hung exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 busy after reset", 32'(busy), 32'd0);
    chk("R10 beat_valid after reset", 32'(beat_valid), 32'd0);
    chk("R10 done after reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1/R4 first address, R2 ordering, R3 writeback, R5 alignment
    for (int i = 0; i < NV; i++) begin
      run_seq(VECS[i].base, VECS[i].mask, VECS[i].mc, VECS[i].stk, VECS[i].ld, VECS[i].wb, 0, 0);
      chk(VECS[i].stk ? "R4 first address" : (VECS[i].base[1:0] != 0 ? "R5 first address" : "R1 first address"),
          got_first, VECS[i].first);
      chk("R2 beat count", 32'(got_n), 32'(VECS[i].n));
      chk("R2 address step", 32'(got_step_ok), 32'd1);
      chk("R2 register order", 32'(got_order_ok), 32'd1);
      chk("R3 new_base", got_nb, VECS[i].nb);
      chk("R3 wb_en", 32'(got_wb), 32'(VECS[i].wb));
      chk("R7 done latency", 32'(got_lat), 32'(VECS[i].n) + 32'd1);
      chk("R7 done single cycle", 32'(got_after), 32'd0);
    end

    // R1: data loaded by each basic mode from words 10..60
    init_mem();
    run_seq(32'h10, 16'h000E, 2'd0, 1'b0, 1'b1, 1'b0, 0, 0);
    chk("R1 inc-after data", {regs[1][7:0], regs[2][7:0], regs[3][7:0]}, {8'd0, 8'd10, 8'd20, 8'd30});
    run_seq(32'h10, 16'h000E, 2'd1, 1'b0, 1'b1, 1'b0, 0, 0);
    chk("R1 inc-before data", {regs[1][7:0], regs[2][7:0], regs[3][7:0]}, {8'd0, 8'd20, 8'd30, 8'd40});
    run_seq(32'h24, 16'h000E, 2'd2, 1'b0, 1'b1, 1'b0, 0, 0);
    chk("R1 dec-after data", {regs[1][7:0], regs[2][7:0], regs[3][7:0]}, {8'd0, 8'd40, 8'd50, 8'd60});
    run_seq(32'h24, 16'h000E, 2'd3, 1'b0, 1'b1, 1'b0, 0, 0);
    chk("R1 dec-before data", {regs[1][7:0], regs[2][7:0], regs[3][7:0]}, {8'd0, 8'd30, 8'd40, 8'd50});

    // R4: full-descending store lands below the base
    init_mem();
    run_seq(32'h40, 16'h000E, 2'd0, 1'b1, 1'b0, 1'b1, 0, 0);
    chk("R4 push word0", mem[32'h34 >> 2], 32'hA1);
    chk("R4 push word2", mem[32'h3C >> 2], 32'hA3);
    chk("R4 push untouched above", mem[32'h40 >> 2], 32'd10 * 32'd13);

    // R9: empty mask
    run_seq(32'h55, 16'h0000, 2'd0, 1'b0, 1'b1, 1'b1, 0, 0);
    chk("R9 no beats", 32'(got_n), 32'd0);
    chk("R9 err", 32'(got_err), 32'd1);
    chk("R9 wb_en low", 32'(got_wb), 32'd0);
    chk("R9 base unchanged", got_nb, 32'h54);
    chk("R9 done latency", 32'(got_lat), 32'd1);

    // R6: back-pressure holds the first beat for 4 cycles
    run_seq(32'h60, 16'h0090, 2'd1, 1'b0, 1'b0, 1'b1, 4, 0);
    chk("R6 beat held under stall", 32'(got_hold_ok), 32'd1);
    chk("R6 first address after stall", got_first, 32'h64);
    chk("R6 beat count after stall", 32'(got_n), 32'd2);
    chk("R6 new_base after stall", got_nb, 32'h68);

    // R8: start during a running sequence is ignored
    run_seq(32'h20, 16'h0007, 2'd0, 1'b0, 1'b1, 1'b1, 0, 1);
    chk("R8 beat count unchanged", 32'(got_n), 32'd3);
    chk("R8 first address unchanged", got_first, 32'h20);
    chk("R8 new_base unchanged", got_nb, 32'h2C);
    chk("R8 done latency", 32'(got_lat), 32'd4);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule